// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Line Transmitter

This block serialises stereo 16-bit audio into a consumer-style digital audio line. Each frame carries two 32-slot subframes, channel 1 (left) then channel 2 (right). Each subframe holds a sync preamble, eight zero auxiliary slots, the audio sample sent least significant bit first, and then validity, user, channel-status and parity slots. The slots are biphase-mark coded onto a single output line. A block counter of 192 frames picks the sync preamble and the channel-status bit that each frame carries.

The line advances one half-slot cell on each clock where `half_en` is high, so the surrounding chip sets the line rate with a clock enable taken from its own audio clock. Sample pairs arrive at any time with a one-cycle strobe and wait in a holding register. The pair in the holding register is taken at the first cell of each frame, so a pair that is not refreshed is sent again. Channel status is built from a few control inputs and a four-entry category table. Dropping `tx_enable` or raising `bypass` silences the line and restarts the stream at frame 0 of a new block.

Top module: `bmc_audio_tx`

## Requirements
- R1: While reset is applied, while `tx_enable` is low, or while `bypass` is high, `line_out` is 0 from the next clock on. Re-enabling restarts at the first cell of frame 0 of a block.
- R2: Slots 0 to 3 of each subframe appear as eight fixed line cells, sent first bit leftmost: 11101000 for channel 1 of frame 0, 11100010 for channel 1 of frames 1 to 191, and 11100100 for every channel 2 subframe.
- R3: For slots 4 to 31, the line inverts at the start of every slot. It inverts again in the second half of the slot only when the slot's bit is 1.
- R4: Slots 4 to 11 carry 0. Slots 12 to 27 carry the sample with bit 0 in slot 12. Channel 1 carries `smp_left` and channel 2 carries `smp_right`.
- R5: Slot 28 (validity) equals the mute flag taken at the start of the frame. While that flag is 1, slots 12 to 27 carry 0. Slot 29 (user) is always 0.
- R6: Slot 31 is chosen so that slots 4 to 31 hold an even number of ones. The line is therefore 0 at the end of every subframe.
- R7: Slot 30 of both subframes of frame n carries channel-status bit n. Bits 0 to 3 are `cs_ctrl[0]` to `cs_ctrl[3]`, bit 15 is `cs_lbit`, bits 24 and 25 are `cs_fs[0]` and `cs_fs[1]`, and bits 28 and 29 are `cs_extra[0]` and `cs_extra[1]`. All other bits outside 8 to 14 are 0.
- R8: Channel-status bits 8 to 14, listed from bit 8 upward, are selected by `cs_cat`: 0 gives 1000000, 1 gives 1001100, 2 gives 1000100, and 3 gives 0101100.
- R9: A pair strobed by `smp_valid` is sent from the next frame start. When no new pair arrives, the previous pair is repeated.
- R10: On a clock where `half_en` is low, the line and the stream position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_en | input | 1 | Advance the line by one half-slot cell |
| tx_enable | input | 1 | Transmitter enable |
| bypass | input | 1 | Pass-through mode; forces the line low |
| smp_valid | input | 1 | Strobe for a new sample pair |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| mute | input | 1 | Mute flag, taken at frame start |
| cs_ctrl | input | 4 | Channel-status bits 0 to 3 |
| cs_lbit | input | 1 | Channel-status bit 15 |
| cs_fs | input | 2 | Channel-status bits 24 and 25 |
| cs_extra | input | 2 | Channel-status bits 28 and 29 |
| cs_cat | input | 2 | Category select for bits 8 to 14 |
| line_out | output | 1 | Biphase-mark coded line |

## Verification
The hardest states to reach from the ports are the block boundary and the category field. The block boundary is where frame 0 must again carry the block-start preamble after 191 other frames. The category field is visible only in frames 8 to 14 of each block. The stimulus reaches every category value by dropping the enable, which restarts the frame count, so each setting is observed within sixteen frames. One uninterrupted run of 194 frames then crosses the block wrap. Randomised gaps in `half_en` are applied during the early frames, so the stream must hold its position across idle clocks.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_CH1   = 2'd1,
    PRE_CH2   = 2'd2
  } pre_kind_e;

  localparam int PRE_SLOTS = 4;
  localparam int AUX_SLOTS = 8;

  // Eight line cells of a sync preamble, first cell in bit 7.
  function automatic logic [7:0] pre_cells(input pre_kind_e kind);
    logic [7:0] cells;
    case (kind)
      PRE_BLOCK: cells = 8'b1110_1000;
      PRE_CH1:   cells = 8'b1110_0010;
      default:   cells = 8'b1110_0100;
    endcase
    return cells;
  endfunction

  // Category field, bit 6 of the result is channel-status bit 8.
  function automatic logic [6:0] category_bits(input logic [1:0] sel);
    logic [6:0] f;
    case (sel)
      2'd0:    f = 7'b100_0000;
      2'd1:    f = 7'b100_1100;
      2'd2:    f = 7'b100_0100;
      default: f = 7'b010_1100;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/bmc_tx_timing.sv
module bmc_tx_timing #(
  parameter int SLOTS        = 32,
  parameter int BLOCK_FRAMES = 192,
  parameter int SLOT_W       = 5,
  parameter int FRAME_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               adv_i,
  output logic               half_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic               chan_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_start_o
);

  localparam logic [SLOT_W-1:0]  LAST_SLOT  = SLOT_W'(SLOTS - 1);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(BLOCK_FRAMES - 1);

  logic               half_q, half_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic               chan_q, chan_d;
  logic [FRAME_W-1:0] frame_q, frame_d;

  always_comb begin
    half_d  = half_q;
    slot_d  = slot_q;
    chan_d  = chan_q;
    frame_d = frame_q;
    if (!run_i) begin
      half_d  = 1'b0;
      slot_d  = '0;
      chan_d  = 1'b0;
      frame_d = '0;
    end else if (adv_i) begin
      half_d = ~half_q;
      if (half_q) begin
        if (slot_q == LAST_SLOT) begin
          slot_d = '0;
          chan_d = ~chan_q;
          if (chan_q) begin
            frame_d = (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
          end
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      slot_q  <= '0;
      chan_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      half_q  <= half_d;
      slot_q  <= slot_d;
      chan_q  <= chan_d;
      frame_q <= frame_d;
    end
  end

  assign half_o        = half_q;
  assign slot_o        = slot_q;
  assign chan_o        = chan_q;
  assign frame_o       = frame_q;
  assign frame_start_o = !half_q && (slot_q == '0) && !chan_q;

endmodule

// File: rtl/bmc_tx_cstat.sv
module bmc_tx_cstat
  import bmc_tx_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [3:0]         ctrl_i,
  input  logic               lbit_i,
  input  logic [1:0]         fs_i,
  input  logic [1:0]         extra_i,
  input  logic [1:0]         cat_i,
  output logic               cs_bit_o
);

  localparam int CAT_LO = 8;
  localparam int CAT_HI = 14;

  logic [6:0] cat_field;
  int         fi;

  always_comb begin
    cat_field = category_bits(cat_i);
    fi        = int'(frame_i);
    cs_bit_o  = 1'b0;
    if (fi < 4) begin
      cs_bit_o = ctrl_i[fi[1:0]];
    end else if (fi >= CAT_LO && fi <= CAT_HI) begin
      cs_bit_o = cat_field[3'(CAT_HI - fi)];
    end else begin
      case (fi)
        15:      cs_bit_o = lbit_i;
        24:      cs_bit_o = fs_i[0];
        25:      cs_bit_o = fs_i[1];
        28:      cs_bit_o = extra_i[0];
        29:      cs_bit_o = extra_i[1];
        default: cs_bit_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/bmc_tx_slotgen.sv
module bmc_tx_slotgen
  import bmc_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOTS    = 32,
  parameter int SLOT_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                adv_i,
  input  logic                frame_start_i,
  input  logic                first_frame_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                half_i,
  input  logic                chan_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_l_i,
  input  logic [SAMPLE_W-1:0] smp_r_i,
  input  logic                mute_i,
  input  logic                cs_bit_i,
  output logic                data_bit_o,
  output logic                is_pre_o,
  output pre_kind_e           pre_kind_o
);

  localparam int AUDIO_LO = PRE_SLOTS + AUX_SLOTS;
  localparam int VAL_SLOT = AUDIO_LO + SAMPLE_W;
  localparam int USR_SLOT = VAL_SLOT + 1;
  localparam int CS_SLOT  = VAL_SLOT + 2;
  localparam int PAR_SLOT = SLOTS - 1;
  localparam int IDX_W    = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] pend_l_q, pend_l_d, pend_r_q, pend_r_d;
  logic [SAMPLE_W-1:0] act_l_q, act_l_d, act_r_q, act_r_d;
  logic                mute_q, mute_d;
  logic                par_q, par_d;
  logic [SAMPLE_W-1:0] cur_sample;
  logic [SLOT_W-1:0]   audio_ofs;
  logic                take_frame;

  assign take_frame = run_i && adv_i && frame_start_i;
  assign is_pre_o   = (slot_i < SLOT_W'(PRE_SLOTS));
  assign pre_kind_o = chan_i ? PRE_CH2 : (first_frame_i ? PRE_BLOCK : PRE_CH1);
  assign cur_sample = chan_i ? act_r_q : act_l_q;
  assign audio_ofs  = slot_i - SLOT_W'(AUDIO_LO);

  // Bit carried by the current slot.
  always_comb begin
    data_bit_o = 1'b0;
    if (slot_i >= SLOT_W'(AUDIO_LO) && slot_i < SLOT_W'(VAL_SLOT)) begin
      data_bit_o = cur_sample[audio_ofs[IDX_W-1:0]] & ~mute_q;
    end else if (slot_i == SLOT_W'(VAL_SLOT)) begin
      data_bit_o = mute_q;
    end else if (slot_i == SLOT_W'(USR_SLOT)) begin
      data_bit_o = 1'b0;
    end else if (slot_i == SLOT_W'(CS_SLOT)) begin
      data_bit_o = cs_bit_i;
    end else if (slot_i == SLOT_W'(PAR_SLOT)) begin
      data_bit_o = par_q;
    end
  end

  always_comb begin
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    act_l_d  = act_l_q;
    act_r_d  = act_r_q;
    mute_d   = mute_q;
    par_d    = par_q;
    if (smp_valid_i) begin
      pend_l_d = smp_l_i;
      pend_r_d = smp_r_i;
    end
    if (take_frame) begin
      act_l_d = pend_l_q;
      act_r_d = pend_r_q;
      mute_d  = mute_i;
    end
    if (!run_i) begin
      par_d = 1'b0;
    end else if (adv_i) begin
      if (is_pre_o) begin
        par_d = 1'b0;
      end else if (half_i && slot_i != SLOT_W'(PAR_SLOT)) begin
        par_d = par_q ^ data_bit_o;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
      act_l_q  <= '0;
      act_r_q  <= '0;
      mute_q   <= 1'b0;
      par_q    <= 1'b0;
    end else begin
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
      act_l_q  <= act_l_d;
      act_r_q  <= act_r_d;
      mute_q   <= mute_d;
      par_q    <= par_d;
    end
  end

endmodule

// File: rtl/bmc_tx_encoder.sv
module bmc_tx_encoder
  import bmc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  input  logic      adv_i,
  input  logic      is_pre_i,
  input  pre_kind_e pre_kind_i,
  input  logic [1:0] pre_slot_i,
  input  logic      half_i,
  input  logic      data_bit_i,
  output logic      line_o
);

  logic       line_q, line_d;
  logic [7:0] cells;
  logic [2:0] cell_idx;

  assign cells    = pre_cells(pre_kind_i);
  assign cell_idx = {pre_slot_i, half_i};

  always_comb begin
    line_d = line_q;
    if (!run_i) begin
      line_d = 1'b0;
    end else if (adv_i) begin
      if (is_pre_i) begin
        line_d = cells[3'd7 - cell_idx];
      end else if (!half_i) begin
        line_d = ~line_q;
      end else begin
        line_d = data_bit_i ? ~line_q : line_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
    end else begin
      line_q <= line_d;
    end
  end

  assign line_o = line_q;

endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
  import bmc_tx_pkg::*;
#(
  parameter int SAMPLE_W     = 16,
  parameter int SLOTS        = 32,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_en,
  input  logic                tx_enable,
  input  logic                bypass,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                mute,
  input  logic [3:0]          cs_ctrl,
  input  logic                cs_lbit,
  input  logic [1:0]          cs_fs,
  input  logic [1:0]          cs_extra,
  input  logic [1:0]          cs_cat,
  output logic                line_out
);

  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int FRAME_W = $clog2(BLOCK_FRAMES);

  logic [1:0]         rst_pipe;
  logic               rst_core_n;
  logic               run;
  logic               adv;
  logic               pos_half;
  logic [SLOT_W-1:0]  pos_slot;
  logic               pos_chan;
  logic [FRAME_W-1:0] pos_frame;
  logic               frame_start;
  logic               cs_bit;
  logic               data_bit;
  logic               is_pre;
  pre_kind_e          pre_kind;

  // Reset asserts at once and releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  assign run = tx_enable && !bypass;
  assign adv = run && half_en;

  bmc_tx_timing #(
    .SLOTS(SLOTS), .BLOCK_FRAMES(BLOCK_FRAMES),
    .SLOT_W(SLOT_W), .FRAME_W(FRAME_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_core_n), .run_i(run), .adv_i(adv),
    .half_o(pos_half), .slot_o(pos_slot), .chan_o(pos_chan),
    .frame_o(pos_frame), .frame_start_o(frame_start)
  );

  bmc_tx_cstat #(.FRAME_W(FRAME_W)) u_cstat (
    .frame_i(pos_frame), .ctrl_i(cs_ctrl), .lbit_i(cs_lbit),
    .fs_i(cs_fs), .extra_i(cs_extra), .cat_i(cs_cat), .cs_bit_o(cs_bit)
  );

  bmc_tx_slotgen #(
    .SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
  ) u_slotgen (
    .clk(clk), .rst_n(rst_core_n), .run_i(run), .adv_i(adv),
    .frame_start_i(frame_start), .first_frame_i(pos_frame == '0),
    .slot_i(pos_slot), .half_i(pos_half), .chan_i(pos_chan),
    .smp_valid_i(smp_valid), .smp_l_i(smp_left), .smp_r_i(smp_right),
    .mute_i(mute), .cs_bit_i(cs_bit),
    .data_bit_o(data_bit), .is_pre_o(is_pre), .pre_kind_o(pre_kind)
  );

  bmc_tx_encoder u_encoder (
    .clk(clk), .rst_n(rst_core_n), .run_i(run), .adv_i(adv),
    .is_pre_i(is_pre), .pre_kind_i(pre_kind), .pre_slot_i(pos_slot[1:0]),
    .half_i(pos_half), .data_bit_i(data_bit), .line_o(line_out)
  );

endmodule

// File: rtl/bmc_tx_checker.sv
module bmc_tx_checker #(
  parameter int SLOT_W       = 5,
  parameter int FRAME_W      = 8,
  parameter int BLOCK_FRAMES = 192
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic               tx_enable_i,
  input logic               bypass_i,
  input logic               half_en_i,
  input logic               run_i,
  input logic               adv_i,
  input logic               line_i,
  input logic [SLOT_W-1:0]  slot_i,
  input logic               half_i,
  input logic [FRAME_W-1:0] frame_i
);

  AST_OFF_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!tx_enable_i || bypass_i) |=> !line_i);  // R1

  AST_PREAMBLE_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (adv_i && slot_i == '0 && !half_i) |=> line_i);  // R2

  AST_SLOT_EDGE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (adv_i && slot_i >= SLOT_W'(4) && !half_i) |=> (line_i != $past(line_i)));  // R3

  AST_SUBFRAME_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    (adv_i && slot_i == '1 && half_i) |=> !line_i);  // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_i && !half_en_i) |=> $stable(line_i));  // R10

  AST_FRAME_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_core_n)
    frame_i < FRAME_W'(BLOCK_FRAMES));  // R2

endmodule

bind bmc_audio_tx bmc_tx_checker #(
  .SLOT_W(SLOT_W), .FRAME_W(FRAME_W), .BLOCK_FRAMES(BLOCK_FRAMES)
) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .tx_enable_i(tx_enable),
  .bypass_i(bypass), .half_en_i(half_en), .run_i(run), .adv_i(adv),
  .line_i(line_out), .slot_i(pos_slot), .half_i(pos_half), .frame_i(pos_frame)
);

// File: tb/bmc_audio_tx_test.sv
module bmc_audio_tx_test;

  logic        clk;
  logic        rst_n;
  logic        half_en;
  logic        tx_enable;
  logic        bypass;
  logic        smp_valid;
  logic [15:0] smp_left;
  logic [15:0] smp_right;
  logic        mute;
  logic [3:0]  cs_ctrl;
  logic        cs_lbit;
  logic [1:0]  cs_fs;
  logic [1:0]  cs_extra;
  logic [1:0]  cs_cat;
  logic        line_out;

  bmc_audio_tx uut (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .tx_enable(tx_enable),
    .bypass(bypass), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .mute(mute), .cs_ctrl(cs_ctrl), .cs_lbit(cs_lbit),
    .cs_fs(cs_fs), .cs_extra(cs_extra), .cs_cat(cs_cat), .line_out(line_out)
  );

  typedef struct {
    logic  val;
    int    frame;
    int    slot;
    string tag;
  } cell_t;

  cell_t       sb[$];
  cell_t       cur;
  int          tests = 0;
  int          fails = 0;
  int          fidx  = 0;
  int          cyc   = 0;
  bit          gap_mode = 0;
  bit          mon_on   = 0;
  logic        adv_q = 0;
  logic        run_q = 0;
  logic        line_prev = 0;
  logic [15:0] pend_l = 0;
  logic [15:0] pend_r = 0;

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic act, input logic exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=<150000", cyc);
      report();
    end
  end

  always @(negedge clk) half_en <= gap_mode ? ($urandom_range(0, 3) != 0) : 1'b1;

  always @(posedge clk) begin
    adv_q <= tx_enable && !bypass && half_en;
    run_q <= tx_enable && !bypass;
  end

  // Monitor: one expected cell per advancing clock.
  always @(negedge clk) begin
    if (mon_on) begin
      if (adv_q) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R1", "cell with empty scoreboard", line_out, 1'b0);
        end else begin
          cur = sb.pop_front();
          chk(line_out === cur.val, cur.tag,
              $sformatf("frame %0d slot %0d", cur.frame, cur.slot), line_out, cur.val);
        end
      end else if (run_q) begin
        chk(line_out === line_prev, "R10", "line moved without half_en", line_out, line_prev);
      end
    end
    line_prev = line_out;
  end

  function automatic logic [6:0] cat_ref(input logic [1:0] s);
    case (s)
      2'd0: return 7'b1000000;
      2'd1: return 7'b1001100;
      2'd2: return 7'b1000100;
      default: return 7'b0101100;
    endcase
  endfunction

  function automatic logic cs_ref(input int n);
    logic [6:0] c = cat_ref(cs_cat);
    if (n < 4) return cs_ctrl[n];
    if (n >= 8 && n <= 14) return c[14 - n];
    if (n == 15) return cs_lbit;
    if (n == 24) return cs_fs[0];
    if (n == 25) return cs_fs[1];
    if (n == 28) return cs_extra[0];
    if (n == 29) return cs_extra[1];
    return 1'b0;
  endfunction

  // Driver side of the scoreboard: expected cells of one frame.
  task automatic push_frame(input bit m, input string atag);
    int f = fidx % 192;
    for (int ch = 0; ch < 2; ch++) begin
      logic [31:0] b = '0;
      logic [15:0] smp = ch ? pend_r : pend_l;
      logic [7:0]  pat;
      logic        lvl, h0, h1, par;
      cell_t       c;
      for (int s = 12; s < 28; s++) b[s] = m ? 1'b0 : smp[s - 12];
      b[28] = m;
      b[29] = 1'b0;
      b[30] = cs_ref(f);
      par = 1'b0;
      for (int s = 4; s < 31; s++) par ^= b[s];
      b[31] = par;
      pat = ch ? 8'b11100100 : ((f == 0) ? 8'b11101000 : 8'b11100010);
      for (int k = 0; k < 8; k++) begin
        c.val = pat[7 - k]; c.frame = f; c.slot = k / 2; c.tag = "R2";
        sb.push_back(c);
      end
      lvl = pat[0];
      for (int s = 4; s < 32; s++) begin
        h0 = ~lvl;
        h1 = b[s] ? ~h0 : h0;
        lvl = h1;
        c.frame = f; c.slot = s;
        c.val = h0; c.tag = "R3";
        sb.push_back(c);
        c.val = h1;
        if (s < 12) c.tag = "R4";
        else if (s < 28) c.tag = atag;
        else if (s < 30) c.tag = "R5";
        else if (s == 30) c.tag = (f >= 8 && f <= 14) ? "R8" : "R7";
        else c.tag = "R6";
        sb.push_back(c);
      end
    end
    fidx++;
  endtask

  task automatic load_pair(input logic [15:0] l, input logic [15:0] r);
    smp_left = l; smp_right = r; smp_valid = 1'b1;
    pend_l = l; pend_r = r;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic start_stream(input string atag);
    @(negedge clk);
    sb.delete();
    fidx = 0;
    push_frame(mute, atag);
    bypass = 1'b0;
    tx_enable = 1'b1;
  endtask

  task automatic next_frame(input bit newp, input logic [15:0] l, input logic [15:0] r,
                            input bit m, input string atag);
    wait (sb.size() <= 2);
    mute = m;
    if (newp) load_pair(l, r);
    push_frame(m, atag);
  endtask

  task automatic stop_stream(input bit use_bypass);
    wait (sb.size() == 40);
    if (use_bypass) bypass = 1'b1;
    else tx_enable = 1'b0;
    sb.delete();
    repeat (3) begin
      @(negedge clk);
      chk(line_out === 1'b0, "R1", use_bypass ? "bypass line" : "disabled line", line_out, 1'b0);
    end
    bypass = 1'b0;
    tx_enable = 1'b0;
  endtask

  initial begin
    rst_n = 0; tx_enable = 0; bypass = 0; smp_valid = 0;
    smp_left = 0; smp_right = 0; mute = 0;
    cs_ctrl = 0; cs_lbit = 0; cs_fs = 0; cs_extra = 0; cs_cat = 0;
    repeat (5) @(negedge clk);
    chk(line_out === 1'b0, "R1", "line in reset", line_out, 1'b0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(line_out === 1'b0, "R1", "line idle after reset", line_out, 1'b0);

    cs_ctrl = 4'b1010; cs_lbit = 1; cs_fs = 2'b10; cs_extra = 2'b01; cs_cat = 2'b01;
    gap_mode = 1; mon_on = 1;
    load_pair(16'hA5C3, 16'h0F01);
    start_stream("R4");
    next_frame(1, 16'h8001, 16'h7FFE, 0, "R4");
    next_frame(1, 16'hFFFF, 16'h0000, 0, "R4");
    next_frame(1, 16'h1234, 16'hFEDC, 1, "R5");   // muted frame
    next_frame(0, 16'h0, 16'h0, 0, "R9");          // repeat of last pair
    next_frame(0, 16'h0, 16'h0, 0, "R9");
    stop_stream(0);
    gap_mode = 0;

    for (int k = 0; k < 4; k++) begin
      cs_cat  = 2'(k);
      cs_ctrl = 4'(k * 5 + 3);
      start_stream("R9");
      for (int f = 1; f < 16; f++)
        next_frame(1, 16'(f * 4099 + k), 16'(f * 257 + 3 * k), 0, "R4");
      stop_stream(k % 2 == 1);
    end

    cs_ctrl = 4'b0110; cs_lbit = 0; cs_fs = 2'b01; cs_extra = 2'b10; cs_cat = 2'b11;
    start_stream("R4");
    for (int f = 1; f < 194; f++)
      next_frame(1, 16'(f * 6151), 16'(~(f * 313)), (f % 37) == 5, (f % 37) == 5 ? "R5" : "R4");
    wait (sb.size() == 0);
    tx_enable = 1'b0;
    repeat (4) @(negedge clk);
    chk(line_out === 1'b0, "R1", "line after final disable", line_out, 1'b0);
    report();
  end

endmodule